// File: doc/BRIEF.md
# Randomized-Mapping Secure Data Cache

This block is a small write-back data cache in which the link between a memory index and a physical line is not wired into an index decoder. Every physical line carries a line-number register holding the logical index it currently serves. A lookup compares the incoming logical index against all of these registers at once, the way a content-addressable memory does. The logical index is `EXTRA_BITS` wider than the physical line number, so the mapping space is larger than the number of real lines.

When no line claims the requested index, the line to replace is picked at random from a free-running 16-bit LFSR. This is the point of the design. An attacker who evicts data and then probes for misses sees the disturbance at an unrelated line, not at the line a fixed mapping would expose.

A lookup reports two separate outcomes. The first is an index hit, meaning a valid line's number register matches. The second is a tag hit, meaning the tag of that matched line also agrees. The processor side is a single request/response port. The memory side has a one-cycle writeback strobe and a fill request that is answered by an acknowledge. Total capacity is set by `LINE_BITS` and `DATA_W`. The defaults are kept small, and a 32 kB configuration only changes those parameters.

Top module: `rmc_cache`

## Requirements
- R1: After reset no line is valid: `req_ready` is 1, `resp_valid`, `mem_rd_req` and `mem_wr_valid` are 0, and the first access to any logical index reports `resp_idx_hit`=0.
- R2: `req_addr` is {tag, logical index}, with the logical index (LINE_BITS+EXTRA_BITS bits) in the low bits. A lookup yields an index hit exactly when a valid line's number register equals that index, and a tag hit when that line's stored tag also equals the tag field.
- R3: A request accepted (`req_valid` and `req_ready` at a rising edge) that tag-hits gives `resp_valid`=1 with the data in the very next cycle, and `req_ready` stays 1.
- R4: On an index miss the replaced line is the low LINE_BITS bits of a 16-bit LFSR sampled in the acceptance cycle. The LFSR loads `SEED` (default 16'hACE1) at reset and shifts left every cycle, with new bit0 = q15^q13^q12^q10. The LFSR is never zero.
- R5: On an index hit with a tag miss, the matched line itself is replaced (`resp_line` is that line), and the response reports `resp_idx_hit`=1, `resp_tag_hit`=0.
- R6: If the line being replaced is valid and dirty, one `mem_wr_valid` cycle carrying address {old tag, old logical index} and the line's data comes before the fill request.
- R7: Writes allocate on a miss. A write hit updates the line and marks it dirty with no memory traffic. Every read returns the most recently written value for its address.
- R8: At no time do two valid lines hold the same logical index.
- R9: A miss is answered when `mem_rd_ack` arrives. The response carries the filled data (or the write data), the lookup's hit flags and the physical line used in `resp_line`.
- R10: Repeated index misses to one logical index land on every physical line over a long run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can take a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | TAG_W+LINE_BITS+EXTRA_BITS | {tag, logical index} |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DATA_W | Line data after the access |
| resp_idx_hit | output | 1 | Lookup found the logical index |
| resp_tag_hit | output | 1 | Lookup found index and tag |
| resp_line | output | LINE_BITS | Physical line that served the access |
| mem_wr_valid | output | 1 | Writeback strobe |
| mem_wr_addr | output | TAG_W+LINE_BITS+EXTRA_BITS | Writeback address |
| mem_wr_data | output | DATA_W | Writeback data |
| mem_rd_req | output | 1 | One-cycle fill request |
| mem_rd_addr | output | TAG_W+LINE_BITS+EXTRA_BITS | Fill address |
| mem_rd_ack | input | 1 | Fill data valid |
| mem_rd_data | input | DATA_W | Fill data |

## Verification
First-touch reads across distinct indexes produce index misses that exercise random placement. Re-reads of the same addresses then separate real hits from lines that random eviction has already displaced. Accesses to an index already present under a new tag show that a tag miss reuses the matched line and does not draw a random victim. A long sweep over four times as many logical indexes as lines, with mixed writes, forces dirty evictions and checks data and writeback addresses against a flat memory. Finally, one index is hammered between unrelated accesses so that its placements can be shown to cover every line.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2,
        ST_WAIT = 2'd3
    } rmc_state_e;
endpackage

// File: rtl/rmc_lfsr.sv
module rmc_lfsr #(
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd = lfsr_q[OUT_W-1:0];

    // R4: a maximal-length register must never fall into the all-zero lock state
    p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 16'd0)
        else $error("lfsr reached zero");
endmodule

// File: rtl/rmc_remap_cam.sv
module rmc_remap_cam #(
    parameter int LINES     = 8,
    parameter int IDX_W     = 5,
    parameter int LINE_BITS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LINES-1:0]            line_vld,
    input  logic [LINES-1:0][IDX_W-1:0] line_num,
    input  logic [IDX_W-1:0]            query,
    output logic                        hit,
    output logic [LINE_BITS-1:0]        hit_line
);
    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = line_vld[g] && (line_num[g] == query);
    end

    always_comb begin
        hit_line = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) hit_line = hit_line | LINE_BITS'(i);
        end
    end

    assign hit = |match;

    // R8: a logical index is owned by at most one valid line
    p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match))
        else $error("several lines own one index");
endmodule

// File: rtl/rmc_cache.sv
module rmc_cache #(
    parameter int          LINE_BITS  = 3,
    parameter int          EXTRA_BITS = 2,
    parameter int          TAG_W      = 8,
    parameter int          DATA_W     = 32,
    parameter logic [15:0] SEED       = 16'hACE1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic                                  req_write,
    input  logic [TAG_W+LINE_BITS+EXTRA_BITS-1:0] req_addr,
    input  logic [DATA_W-1:0]                     req_wdata,
    output logic                                  resp_valid,
    output logic [DATA_W-1:0]                     resp_rdata,
    output logic                                  resp_idx_hit,
    output logic                                  resp_tag_hit,
    output logic [LINE_BITS-1:0]                  resp_line,
    output logic                                  mem_wr_valid,
    output logic [TAG_W+LINE_BITS+EXTRA_BITS-1:0] mem_wr_addr,
    output logic [DATA_W-1:0]                     mem_wr_data,
    output logic                                  mem_rd_req,
    output logic [TAG_W+LINE_BITS+EXTRA_BITS-1:0] mem_rd_addr,
    input  logic                                  mem_rd_ack,
    input  logic [DATA_W-1:0]                     mem_rd_data
);
    import rmc_pkg::*;

    localparam int LINES  = 1 << LINE_BITS;
    localparam int IDX_W  = LINE_BITS + EXTRA_BITS;
    localparam int ADDR_W = TAG_W + IDX_W;

    typedef struct packed {
        rmc_state_e                   state;
        logic [LINES-1:0]             vld;
        logic [LINES-1:0]             dirty;
        logic [LINES-1:0][IDX_W-1:0]  lnum;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] data;
        logic [ADDR_W-1:0]            pend_addr;
        logic                         pend_write;
        logic [DATA_W-1:0]            pend_wdata;
        logic                         pend_ihit;
        logic [LINE_BITS-1:0]         pend_line;
        logic                         rsp_valid;
        logic [DATA_W-1:0]            rsp_data;
        logic                         rsp_ihit;
        logic                         rsp_thit;
        logic [LINE_BITS-1:0]         rsp_line;
    } regs_t;

    regs_t r_d, r_q;

    logic [TAG_W-1:0]     lk_tag;
    logic [IDX_W-1:0]     lk_idx;
    logic                 cam_hit;
    logic [LINE_BITS-1:0] cam_line;
    logic                 lk_tag_hit;
    logic [LINE_BITS-1:0] rnd_line;
    logic [LINE_BITS-1:0] vic;
    logic [TAG_W-1:0]     pend_tag;
    logic [IDX_W-1:0]     pend_idx;

    assign lk_tag   = req_addr[ADDR_W-1:IDX_W];
    assign lk_idx   = req_addr[IDX_W-1:0];
    assign pend_tag = r_q.pend_addr[ADDR_W-1:IDX_W];
    assign pend_idx = r_q.pend_addr[IDX_W-1:0];

    rmc_remap_cam #(.LINES(LINES), .IDX_W(IDX_W), .LINE_BITS(LINE_BITS)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_vld (r_q.vld),
        .line_num (r_q.lnum),
        .query    (lk_idx),
        .hit      (cam_hit),
        .hit_line (cam_line)
    );

    rmc_lfsr #(.SEED(SEED), .OUT_W(LINE_BITS)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd_line)
    );

    assign lk_tag_hit = cam_hit && (r_q.tag[cam_line] == lk_tag);
    assign vic        = cam_hit ? cam_line : rnd_line;

    always_comb begin
        r_d = r_q;
        r_d.rsp_valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (lk_tag_hit) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_ihit  = 1'b1;
                        r_d.rsp_thit  = 1'b1;
                        r_d.rsp_line  = cam_line;
                        if (req_write) begin
                            r_d.data[cam_line]  = req_wdata;
                            r_d.dirty[cam_line] = 1'b1;
                            r_d.rsp_data        = req_wdata;
                        end else begin
                            r_d.rsp_data = r_q.data[cam_line];
                        end
                    end else begin
                        r_d.pend_addr  = req_addr;
                        r_d.pend_write = req_write;
                        r_d.pend_wdata = req_wdata;
                        r_d.pend_ihit  = cam_hit;
                        r_d.pend_line  = vic;
                        r_d.state      = (r_q.vld[vic] && r_q.dirty[vic]) ? ST_WB : ST_FILL;
                    end
                end
            end
            ST_WB:   r_d.state = ST_FILL;
            ST_FILL: r_d.state = ST_WAIT;
            ST_WAIT: begin
                if (mem_rd_ack) begin
                    r_d.vld[r_q.pend_line]   = 1'b1;
                    r_d.dirty[r_q.pend_line] = r_q.pend_write;
                    r_d.lnum[r_q.pend_line]  = pend_idx;
                    r_d.tag[r_q.pend_line]   = pend_tag;
                    r_d.data[r_q.pend_line]  = r_q.pend_write ? r_q.pend_wdata : mem_rd_data;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = r_q.pend_write ? r_q.pend_wdata : mem_rd_data;
                    r_d.rsp_ihit  = r_q.pend_ihit;
                    r_d.rsp_thit  = 1'b0;
                    r_d.rsp_line  = r_q.pend_line;
                    r_d.state     = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready    = (r_q.state == ST_IDLE);
    assign resp_valid   = r_q.rsp_valid;
    assign resp_rdata   = r_q.rsp_data;
    assign resp_idx_hit = r_q.rsp_ihit;
    assign resp_tag_hit = r_q.rsp_thit;
    assign resp_line    = r_q.rsp_line;
    assign mem_wr_valid = (r_q.state == ST_WB);
    assign mem_wr_addr  = {r_q.tag[r_q.pend_line], r_q.lnum[r_q.pend_line]};
    assign mem_wr_data  = r_q.data[r_q.pend_line];
    assign mem_rd_req   = (r_q.state == ST_FILL);
    assign mem_rd_addr  = r_q.pend_addr;

    // R3: a tag hit is answered in the next cycle
    p_hit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_tag_hit) |=> (resp_valid && resp_tag_hit))
        else $error("hit not answered next cycle");

    // R7: a hit causes no memory traffic
    p_hit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_tag_hit) |=> !(mem_rd_req || mem_wr_valid))
        else $error("memory traffic on hit");

    // R9: a miss stalls the port until it is filled
    p_miss_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lk_tag_hit) |=> !req_ready)
        else $error("miss did not stall");

    // R6: a writeback is followed at once by the fill request
    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |=> mem_rd_req)
        else $error("writeback not followed by fill");
endmodule

// File: tb/tb_rmc_cache.sv
`timescale 1ns/1ps
module tb_rmc_cache;
    localparam int LB     = 3;
    localparam int EB     = 2;
    localparam int TW     = 8;
    localparam int DW     = 32;
    localparam int LINES  = 1 << LB;
    localparam int IW     = LB + EB;
    localparam int NIDX   = 1 << IW;
    localparam int AW     = TW + IW;
    localparam logic [15:0] SEED = 16'hACE1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, resp_valid, resp_idx_hit, resp_tag_hit;
    logic [DW-1:0] resp_rdata;
    logic [LB-1:0] resp_line;
    logic mem_wr_valid, mem_rd_req;
    logic [AW-1:0] mem_wr_addr, mem_rd_addr;
    logic [DW-1:0] mem_wr_data;
    logic mem_rd_ack = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;

    always #2 clk = ~clk;

    rmc_cache #(.LINE_BITS(LB), .EXTRA_BITS(EB), .TAG_W(TW), .DATA_W(DW), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .resp_idx_hit(resp_idx_hit), .resp_tag_hit(resp_tag_hit), .resp_line(resp_line),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return (DW'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // memory model and independent random-source model
    logic [DW-1:0] mem [int];
    logic [DW-1:0] truth [int];
    int rd_wait = 0;
    logic [AW-1:0] rd_addr_q;
    int wb_count = 0;
    int rd_count = 0;
    logic [AW-1:0] last_wb_addr;
    logic [15:0] ref_lfsr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_lfsr <= SEED;
        else        ref_lfsr <= {ref_lfsr[14:0], ref_lfsr[15] ^ ref_lfsr[13] ^ ref_lfsr[12] ^ ref_lfsr[10]};
    end

    function automatic logic [DW-1:0] mem_get(input logic [AW-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : init_val(a);
    endfunction

    always @(negedge clk) begin
        mem_rd_ack = 1'b0;
        if (rd_wait > 0) begin
            rd_wait--;
            if (rd_wait == 0) begin
                mem_rd_ack  = 1'b1;
                mem_rd_data = mem_get(rd_addr_q);
            end
        end
        if (rst_n && mem_wr_valid) begin
            mem[int'(mem_wr_addr)] = mem_wr_data;
            last_wb_addr = mem_wr_addr;
            wb_count++;
        end
        if (rst_n && mem_rd_req) begin
            rd_addr_q = mem_rd_addr;
            rd_wait = 2;
            rd_count++;
        end
    end

    // behavioural cache contents: logical index -> line, tag, dirty
    int map_line [int];
    int owner [int];
    int map_tag [int];
    bit map_dirty [int];
    bit placed3 [LINES];
    int misses3 = 0;
    int victims_seen [LINES];

    task automatic access(input bit wr, input int tg, input int ix, input logic [DW-1:0] wd);
        logic [AW-1:0] a;
        bit e_ih, e_th, e_wb;
        int e_line, wb0, rd0, lat;
        logic [AW-1:0] e_wb_addr;
        logic [DW-1:0] e_data;
        a = {TW'(tg), IW'(ix)};
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        e_ih = map_line.exists(ix);
        e_th = e_ih && (map_tag[ix] == tg);
        e_line = e_ih ? map_line[ix] : int'(ref_lfsr[LB-1:0]);
        e_wb = 0;
        e_wb_addr = '0;
        if (!e_th && owner.exists(e_line)) begin
            int old;
            old = owner[e_line];
            if (map_dirty[old]) begin
                e_wb = 1;
                e_wb_addr = {TW'(map_tag[old]), IW'(old)};
            end
        end
        e_data = wr ? wd : (truth.exists(int'(a)) ? truth[int'(a)] : init_val(a));
        if (!e_ih) begin
            if (owner.exists(e_line)) map_line.delete(owner[e_line]);
            owner[e_line] = ix;
            map_line[ix] = e_line;
            map_dirty[ix] = 0;
            victims_seen[e_line]++;
            if (ix == 3) begin placed3[e_line] = 1; misses3++; end
        end
        if (!e_th) map_dirty[ix] = 0;
        map_tag[ix] = tg;
        if (wr) begin truth[int'(a)] = wd; map_dirty[ix] = 1; end
        wb0 = wb_count; rd0 = rd_count;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid) begin @(negedge clk); lat++; end
        check(resp_rdata == e_data, "R7", "data", resp_rdata, e_data);
        check(resp_idx_hit == e_ih, "R2", "index hit", resp_idx_hit, e_ih);
        check(resp_tag_hit == e_th, "R2", "tag hit", resp_tag_hit, e_th);
        if (e_th) begin
            check(lat == 1, "R3", "hit latency", lat, 1);
            check(req_ready == 1'b1, "R3", "ready after hit", req_ready, 1);
            check(rd_count == rd0 && wb_count == wb0, "R7", "traffic on hit", rd_count - rd0, 0);
        end else if (e_ih) begin
            check(resp_line == e_line, "R5", "reused line", resp_line, e_line);
        end else begin
            check(resp_line == e_line, "R4", "random victim", resp_line, e_line);
        end
        if (!e_th) begin
            check(rd_count == rd0 + 1, "R9", "one fill", rd_count - rd0, 1);
            check(wb_count == wb0 + (e_wb ? 1 : 0), "R6", "writeback count", wb_count - wb0, e_wb);
            if (e_wb) check(last_wb_addr == e_wb_addr, "R6", "writeback addr", last_wb_addr, e_wb_addr);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
        check(mem_rd_req == 1'b0 && mem_wr_valid == 1'b0, "R1", "mem idle", mem_rd_req, 0);

        // R1/R4: first touches all miss and take random lines
        for (int i = 0; i < LINES; i++) access(0, 1, i, '0);
        // R3: rereads hit unless randomly displaced
        for (int i = 0; i < LINES; i++) access(0, 1, i, '0);
        // R7: write hits and rereads
        for (int i = 0; i < 4; i++) access(1, 1, i, 32'hC0DE_0000 + i);
        for (int i = 0; i < 4; i++) access(0, 1, i, '0);
        // R5: same index, other tag, reuses its line
        access(0, 1, 9, '0);
        access(0, 2, 9, '0);
        access(1, 3, 9, 32'hFACE_0009);
        access(0, 2, 9, '0);
        access(0, 3, 9, '0);

        // R6/R7: wide sweep with dirty evictions
        for (int i = 0; i < 400; i++) begin
            int ix, tg;
            ix = (i * 7) % NIDX;
            tg = (i / NIDX) % 4;
            access((i % 3) == 0, tg, ix, 32'h1000_0000 + i);
        end

        // R10: hammer one index between unrelated accesses
        for (int r = 0; r < 300; r++) begin
            access(0, 0, 3, '0);
            for (int j = 0; j < 8; j++) access(0, 0, 4 + ((r + j * 3) % (NIDX - 4)), '0);
        end
        begin
            int cnt;
            cnt = 0;
            for (int l = 0; l < LINES; l++) if (placed3[l]) cnt++;
            check(cnt == LINES, "R10", "lines used by index 3", cnt, LINES);
            check(misses3 >= LINES, "R10", "index 3 misses", misses3, LINES);
            cnt = 0;
            for (int l = 0; l < LINES; l++) if (victims_seen[l] > 0) cnt++;
            check(cnt == LINES, "R4", "victims over all lines", cnt, LINES);
        end
        // R8: every index still mapped reads back its latest value
        foreach (map_line[k]) access(0, map_tag[k], k, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule